// File: doc/BRIEF.md
# Queue Occupancy DVFS Controller

This block picks the operating point of a trailing (checking) core in a redundant-execution pair. The leading core sends branch outcomes and load values into two queues in front of the trailing core. How full those queues are shows how far the trailing core has fallen behind. A full queue means the checker is too slow and is about to stall the leading core. A nearly empty queue means the checker is faster than it needs to be and is wasting power.

A free-running timer samples both occupancy counts once per sampling period. At each sample the controller moves the level index up one step, moves it down one step, or keeps it. After any change, a busy flag stays high for a fixed settling time so the external regulator can reach the new voltage. Samples that arrive during that time are discarded. The level index goes to the external regulator and clock generator. Index 0 is 0.5 V and each index adds 0.125 V, up to index 4 at 1.0 V. Clock frequency is proportional to voltage, so index 4 is full speed.

Top module: `qdvfs_ctrl`

## Requirements
- R1: While reset is active and until the first accepted sample, `level` equals NUM_LEVELS-1 (index 4, 1.0 V, full frequency) and `regBusy` is 0.
- R2: Decisions are made only at sample instants. The first instant is the SAMPLE_PERIOD-th rising clock edge after reset is released, and each later instant follows SAMPLE_PERIOD edges after the previous one. `level` changes at no other edge.
- R3: At an accepted sample where either occupancy is strictly greater than HIGH_THR and `level` is below the top index, `level` rises by exactly one.
- R4: At an accepted sample where neither occupancy exceeds HIGH_THR, at least one is strictly below LOW_THR, and `level` is above 0, `level` falls by exactly one.
- R5: When one queue is above HIGH_THR and the other is below LOW_THR at the same sample, the raise condition wins. At the top index this case holds the level and never lowers it.
- R6: When both occupancies lie within the closed range [LOW_THR, HIGH_THR], `level` is held. Values equal to a threshold count as inside the range.
- R7: `level` saturates at 0 and at NUM_LEVELS-1. A sample that would step past either end changes nothing and does not raise `regBusy`.
- R8: After every change of `level`, `regBusy` is 1 for exactly SETTLE_CYCLES clock cycles, starting in the cycle of the change.
- R9: A sample instant at which `regBusy` is 1 is ignored, whatever the occupancies are.
- R10: `level` is a binary index, 0 = 0.5 V, in 0.125 V steps. It never exceeds NUM_LEVELS-1 and never moves by more than one index at a single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| boqOcc | input | OCC_W | Current entry count of the branch-outcome queue |
| lvqOcc | input | OCC_W | Current entry count of the load-value queue |
| level | output | LVL_W | Operating level index for the regulator |
| regBusy | output | 1 | High while the regulator is settling after a step |

## Verification
If the sample timer is wrong, the first level change lands at the wrong edge, at least one period early or late. Every later change then shifts too, and this shows within one or two sample periods.

A wrong settle counter shows in two ways. `regBusy` drops at the wrong cycle right after the first step. An ignored sample also gets acted on, so two steps come one period apart instead of two.

If the comparators or the priority are wrong, `level` moves in the wrong direction at the first sample where the queue fill is mixed or sits exactly on a threshold. Saturation faults show when the index wraps past 0 or 4 one period after reaching an end.

// File: rtl/qdvfs_pkg.sv
package qdvfs_pkg;
  // one-cycle step request from control to datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepCmd_t;

  // threshold and range status from datapath to control
  typedef struct packed {
    logic anyHigh;
    logic anyLow;
    logic atTop;
    logic atBottom;
  } occFlags_t;
endpackage

// File: rtl/qdvfs_level_dp.sv
module qdvfs_level_dp
  import qdvfs_pkg::*;
#(
  parameter int OCC_W      = 11,
  parameter int LOW_THR    = 16,
  parameter int HIGH_THR   = 128,
  parameter int NUM_LEVELS = 5,
  parameter int LVL_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCC_W-1:0] boqOcc,
  input  logic [OCC_W-1:0] lvqOcc,
  input  stepCmd_t         cmd,
  output logic [LVL_W-1:0] level,
  output occFlags_t        flags
);
  localparam int NQ = 2;
  localparam logic [OCC_W-1:0] LOW_V  = OCC_W'(LOW_THR);
  localparam logic [OCC_W-1:0] HIGH_V = OCC_W'(HIGH_THR);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LEVELS - 1);

  logic [NQ-1:0][OCC_W-1:0] occ;
  logic [NQ-1:0]            overHi;
  logic [NQ-1:0]            underLo;
  logic [LVL_W-1:0]         levelQ;

  assign occ = {lvqOcc, boqOcc};

  for (genvar q = 0; q < NQ; q++) begin : g_cmp
    assign overHi[q]  = occ[q] > HIGH_V;
    assign underLo[q] = occ[q] < LOW_V;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            levelQ <= TOP_LVL;
    else if (cmd.stepUp)  levelQ <= levelQ + 1'b1;
    else if (cmd.stepDown) levelQ <= levelQ - 1'b1;
  end

  assign level          = levelQ;
  assign flags.anyHigh  = |overHi;
  assign flags.anyLow   = |underLo;
  assign flags.atTop    = (levelQ == TOP_LVL);
  assign flags.atBottom = (levelQ == '0);
endmodule

// File: rtl/qdvfs_step_ctl.sv
module qdvfs_step_ctl
  import qdvfs_pkg::*;
#(
  parameter int SAMPLE_PERIOD = 25000,
  parameter int SETTLE_CYCLES = 20
) (
  input  logic      clk,
  input  logic      rstN,
  input  occFlags_t flags,
  output stepCmd_t  cmd,
  output logic      regBusy
);
  localparam int CNT_W = (SAMPLE_PERIOD > 1) ? $clog2(SAMPLE_PERIOD) : 1;
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_PERIOD - 1);
  localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] sampleCnt;
  logic [SET_W-1:0] settleCnt;
  logic             sampleTick;
  logic             accept;
  logic             busyNow;

  assign sampleTick = (sampleCnt == LAST_CNT);
  assign busyNow    = (settleCnt != '0);
  assign accept     = sampleTick && !busyNow;

  // raise has priority; a raise request at the top masks any lowering
  assign cmd.stepUp   = accept && flags.anyHigh && !flags.atTop;
  assign cmd.stepDown = accept && !flags.anyHigh && flags.anyLow && !flags.atBottom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sampleCnt <= '0;
    else if (sampleTick) sampleCnt <= '0;
    else                 sampleCnt <= sampleCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          settleCnt <= '0;
    else if (cmd.stepUp || cmd.stepDown) settleCnt <= SET_LOAD;
    else if (busyNow)                   settleCnt <= settleCnt - 1'b1;
  end

  assign regBusy = busyNow;
endmodule

// File: rtl/qdvfs_ctrl.sv
module qdvfs_ctrl
  import qdvfs_pkg::*;
#(
  parameter int QUEUE_SIZE    = 1024,
  parameter int OCC_W         = $clog2(QUEUE_SIZE + 1),
  parameter int LOW_THR       = 16,
  parameter int HIGH_THR      = QUEUE_SIZE / 8,
  parameter int NUM_LEVELS    = 5,
  parameter int LVL_W         = $clog2(NUM_LEVELS),
  parameter int SAMPLE_PERIOD = 25000,
  parameter int SETTLE_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCC_W-1:0] boqOcc,
  input  logic [OCC_W-1:0] lvqOcc,
  output logic [LVL_W-1:0] level,
  output logic             regBusy
);
  stepCmd_t  cmd;
  occFlags_t flags;

  qdvfs_level_dp #(
    .OCC_W(OCC_W), .LOW_THR(LOW_THR), .HIGH_THR(HIGH_THR),
    .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .boqOcc(boqOcc), .lvqOcc(lvqOcc),
    .cmd(cmd), .level(level), .flags(flags)
  );

  qdvfs_step_ctl #(
    .SAMPLE_PERIOD(SAMPLE_PERIOD), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .flags(flags), .cmd(cmd), .regBusy(regBusy)
  );
endmodule

// File: rtl/qdvfs_ctrl_chk.sv
module qdvfs_ctrl_chk #(
  parameter int OCC_W      = 11,
  parameter int LOW_THR    = 16,
  parameter int HIGH_THR   = 128,
  parameter int NUM_LEVELS = 5,
  parameter int LVL_W      = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [OCC_W-1:0] boqOcc,
  input logic [OCC_W-1:0] lvqOcc,
  input logic [LVL_W-1:0] level,
  input logic             regBusy
);
  localparam logic [OCC_W-1:0] LOW_V   = OCC_W'(LOW_THR);
  localparam logic [OCC_W-1:0] HIGH_V  = OCC_W'(HIGH_THR);
  localparam logic [LVL_W:0]   TOP_EXT = (LVL_W+1)'(NUM_LEVELS - 1);

  logic           hiReq;
  logic           loReq;
  logic [LVL_W:0] lvlExt;

  assign hiReq  = (boqOcc > HIGH_V) || (lvqOcc > HIGH_V);
  assign loReq  = (boqOcc < LOW_V) || (lvqOcc < LOW_V);
  assign lvlExt = {1'b0, level};

  // R10: index stays in range
  p_level_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    lvlExt <= TOP_EXT);

  // R10: at most one index per edge
  p_single_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(level) |-> (lvlExt == {1'b0, $past(level)} + 1'b1) ||
                        (lvlExt + 1'b1 == {1'b0, $past(level)}));

  // R8: settling flag raised together with a change
  p_busy_on_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(level) |-> regBusy);

  // R9: no change while the regulator settles
  p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(regBusy) |-> $stable(level));

  // R3, R5: a rise needs a queue above the high threshold
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    (level > $past(level)) |-> $past(hiReq));

  // R4, R5: a fall needs a low queue and no high queue
  p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    (level < $past(level)) |-> $past(loReq && !hiReq));
endmodule

bind qdvfs_ctrl qdvfs_ctrl_chk #(
  .OCC_W(OCC_W), .LOW_THR(LOW_THR), .HIGH_THR(HIGH_THR),
  .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rstN(rstN), .boqOcc(boqOcc), .lvqOcc(lvqOcc),
  .level(level), .regBusy(regBusy)
);

// File: tb/qdvfs_ctrl_tb_top.sv
`timescale 1ns/1ps
module qdvfs_ctrl_tb_top;
  localparam int QSIZE  = 1024;
  localparam int OW     = 11;
  localparam int LOWT   = 16;
  localparam int HIGHT  = QSIZE / 8;
  localparam int NLVL   = 5;
  localparam int LW     = 3;
  localparam int PERIOD = 16;
  localparam int SETTLE = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [OW-1:0] boqOcc = '0;
  logic [OW-1:0] lvqOcc = '0;
  logic [LW-1:0] level;
  logic          regBusy;

  int    nVec = 0;
  int    nBad = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  qdvfs_ctrl #(
    .QUEUE_SIZE(QSIZE), .OCC_W(OW), .LOW_THR(LOWT), .HIGH_THR(HIGHT),
    .NUM_LEVELS(NLVL), .LVL_W(LW), .SAMPLE_PERIOD(PERIOD), .SETTLE_CYCLES(SETTLE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .boqOcc(boqOcc), .lvqOcc(lvqOcc),
    .level(level), .regBusy(regBusy)
  );

  // expected behaviour from the requirements
  int mCnt, mLvl, mSettle;

  function automatic int nextLevel(int lvl, int b, int l);
    if ((b > HIGHT || l > HIGHT)) return (lvl < NLVL-1) ? lvl + 1 : lvl;
    if ((b < LOWT || l < LOWT))   return (lvl > 0) ? lvl - 1 : lvl;
    return lvl;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mLvl = NLVL - 1; mSettle = 0;
    end else begin
      int nl;
      nl = mLvl;
      if (mCnt == PERIOD - 1 && mSettle == 0)
        nl = nextLevel(mLvl, int'(boqOcc), int'(lvqOcc));
      mCnt = (mCnt == PERIOD - 1) ? 0 : mCnt + 1;
      if (nl != mLvl) mSettle = SETTLE;
      else if (mSettle != 0) mSettle = mSettle - 1;
      mLvl = nl;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(curReq, int'(level), mLvl, "level");
      check(curReq, int'(regBusy), (mSettle != 0) ? 1 : 0, "regBusy");
    end
  endtask

  function automatic int pick(int cls);
    if (cls == 0) return int'($urandom_range(LOWT - 1, 0));
    if (cls == 1) return int'($urandom_range(HIGHT, LOWT));
    return int'($urandom_range(QSIZE, HIGHT + 1));
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", int'(level), NLVL - 1, "reset level");
    check("R1", int'(regBusy), 0, "reset busy");
    rstN = 1'b1;
    // R1, R2: no change before the first sample; R6 boundary values hold
    curReq = "R6";
    boqOcc = OW'(LOWT); lvqOcc = OW'(HIGHT);
    run(PERIOD - 1);
    check("R2", int'(level), NLVL - 1, "level before first sample");
    run(80);
    check("R6", int'(level), NLVL - 1, "level held at thresholds");
    // R4 down to bottom, then R7 saturation
    curReq = "R4";
    boqOcc = OW'(50); lvqOcc = OW'(5);
    run(220);
    check("R7", int'(level), 0, "bottom saturation");
    check("R7", int'(regBusy), 0, "no busy at bottom");
    // R5 mixed fill raises
    curReq = "R5";
    boqOcc = OW'(200); lvqOcc = OW'(3);
    run(220);
    check("R3", int'(level), NLVL - 1, "top reached");
    check("R7", int'(regBusy), 0, "no busy at top");
    // R8/R9 timing and random mixing
    curReq = "R8 R9 R2";
    for (int k = 0; k < 150; k++) begin
      boqOcc = OW'(pick(int'($urandom_range(2, 0))));
      lvqOcc = OW'(pick(int'($urandom_range(2, 0))));
      run(int'($urandom_range(60, 5)));
    end
    curReq = "R10";
    boqOcc = OW'(QSIZE); lvqOcc = OW'(QSIZE);
    run(200);
    check("R10", int'(level), NLVL - 1, "full index");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule